// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block adds time-stamping of external events to a general-purpose timer. It holds a configurable number of capture channels (two by default). All of them share the count value and the count-advance strobe of a free-running counter that lives in the enclosing timer. Each channel watches an asynchronous input pin and passes it through a synchronizer. It then looks for the edge polarity that software has chosen. When such an edge arrives, the channel freezes the current count into a read-only capture register and raises its own event flag.

Software drives three word-wide write targets on a simple register write port. The first is a control word that carries one 2-bit edge-select field per channel. The second is a status word, where writing a one to a flag position clears that flag. The third is an interrupt-enable word. A single interrupt line reports any flag whose enable bit is set. A capture is committed only in a cycle where the counter advances. An edge that arrives while the counter is paused waits for the next advancing cycle, so the stored value always matches a count the timer has actually produced.

Top module: `edge_capture_unit`

## Requirements
- R1: After a synchronous reset, every capture register reads 0, every flag is 0 and the interrupt line is 0.
- R2: Edge-select code 01 stores the count on a rising pin edge only; a falling edge leaves the capture value and the flag untouched.
- R3: Edge-select code 10 stores the count on a falling pin edge only; a rising edge has no effect.
- R4: Edge-select code 11 stores the count on both rising and falling pin edges.
- R5: Edge-select code 00 blocks all captures and flag setting, while the last captured value stays readable.
- R6: With the counter advancing every cycle, a pin change driven before clock edge k is stored with the count presented before edge k+2, and the flag rises at that same edge k+2. It is not visible before then.
- R7: Writes to address 0 (control) load channel n's edge-select from bits [17+2n:16+2n], so channel 0 uses bits 17:16 and channel 1 uses bits 19:18. Writes to addresses 2 and 3 leave the edge-select codes unchanged.
- R8: A new capture overwrites the stored value even while the flag is still set, and the flag stays 1.
- R9: A write to address 1 (status) with bit 3+n set clears channel n's flag. A zero in that bit, or a one in another channel's bit, leaves the flag set.
- R10: When a flag clear and a new capture on the same channel land at the same clock edge, the flag stays 1 and the new value is stored.
- R11: Address 2 holds per-channel interrupt enables at bit 3+n. The interrupt line is registered: one clock after any flag is set together with its enable, it reads 1, and one clock after no such pair remains, it reads 0.
- R12: An edge detected while the count-advance strobe is low is held. It is stored at the first clock edge at which the strobe is high, with the count presented in that cycle.
- R13: Channels are independent: an edge on one channel's pin never changes another channel's capture value or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current value of the shared counter |
| cnt_tick | input | 1 | High in cycles where the counter advances |
| cap_pin | input | NUM_CH | Asynchronous capture inputs, bit n for channel n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 control, 1 status (write one to clear), 2 interrupt enable |
| wr_data | input | BUS_W | Write data |
| cap_val | output | NUM_CH*CNT_W | Captured counts, channel n in bits [n*CNT_W +: CNT_W] |
| cap_flag | output | NUM_CH | Per-channel capture event flags |
| irq | output | 1 | Registered OR of flags that have their enable bit set |

## Verification
The bench builds the block with its default parameters: a 32-bit count, two channels and a two-stage synchronizer. With these values the exact two-cycle pin-to-capture latency can be checked against a count that the bench itself advances. Two channels make it possible to show that the second edge-select field sits at bits 19:18, and that one pin cannot disturb the other channel. The bench starts the count near 0x10000000, so a capture that dropped upper bits or stored a stale count would show a wrong value. It also pauses the count-advance strobe to exercise the held-edge path.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

  // Edge-select codes for one channel.
  typedef enum logic [1:0] {
    CAP_OFF  = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_BOTH = 2'b11
  } cap_mode_e;

  // Write targets on the register port.
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_IEN  = 2'd2;

  // Field placement inside the written words.
  localparam int MODE_LSB = 16;
  localparam int FLAG_LSB = 3;

endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ecu_edge.sv
module ecu_edge
  import ecu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic [1:0] mode,
  output logic       hit
);
  logic prev_q;
  logic rise, fall;

  // The previous sample follows the pin in every mode, so enabling a mode
  // never sees a stale level difference as an edge.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    case (cap_mode_e'(mode))
      CAP_RISE: hit = rise;
      CAP_FALL: hit = fall;
      CAP_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ecu_chan.sv
module ecu_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             tick,
  input  logic             armed,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap,
  output logic             flag
);
  logic pend_q;
  logic commit;

  assign commit = (hit | pend_q) & tick & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      cap    <= '0;
      flag   <= 1'b0;
    end else begin
      pend_q <= armed & ~tick & (hit | pend_q);
      if (commit) cap <= cnt;
      flag <= commit | (flag & ~clr);
    end
  end
endmodule

// File: rtl/ecu_regs.sv
module ecu_regs
  import ecu_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int BUS_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [BUS_W-1:0]      wr_data,
  output logic [NUM_CH-1:0][1:0] mode,
  output logic [NUM_CH-1:0]     ie,
  output logic [NUM_CH-1:0]     clr
);
  logic unused_bits;
  assign unused_bits = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
      ie   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL) begin
        for (int i = 0; i < NUM_CH; i++) mode[i] <= wr_data[MODE_LSB + 2*i +: 2];
      end
      if (wr_addr == ADDR_IEN) begin
        for (int i = 0; i < NUM_CH; i++) ie[i] <= wr_data[FLAG_LSB + i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      clr[i] = wr_en && (wr_addr == ADDR_STAT) && wr_data[FLAG_LSB + i];
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int CNT_W       = 32,
  parameter int NUM_CH      = 2,
  parameter int BUS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W-1:0]        cnt_val,
  input  logic                    cnt_tick,
  input  logic [NUM_CH-1:0]       cap_pin,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [BUS_W-1:0]        wr_data,
  output logic [NUM_CH*CNT_W-1:0] cap_val,
  output logic [NUM_CH-1:0]       cap_flag,
  output logic                    irq
);
  logic [NUM_CH-1:0][1:0] mode_q;
  logic [NUM_CH-1:0]      ie_q;
  logic [NUM_CH-1:0]      clr_w;

  ecu_regs #(.NUM_CH(NUM_CH), .BUS_W(BUS_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode    (mode_q),
    .ie      (ie_q),
    .clr     (clr_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic lvl;
    logic hit;

    ecu_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (cap_pin[g]),
      .dout (lvl)
    );

    ecu_edge u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (lvl),
      .mode (mode_q[g]),
      .hit  (hit)
    );

    ecu_chan #(.CNT_W(CNT_W)) u_chan (
      .clk   (clk),
      .rst   (rst),
      .hit   (hit),
      .tick  (cnt_tick),
      .armed (mode_q[g] != 2'b00),
      .clr   (clr_w[g]),
      .cnt   (cnt_val),
      .cap   (cap_val[g*CNT_W +: CNT_W]),
      .flag  (cap_flag[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(cap_flag & ie_q);
  end
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker
  import ecu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 2,
  parameter int BUS_W  = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [1:0]              wr_addr,
  input logic [BUS_W-1:0]        wr_data,
  input logic [NUM_CH*CNT_W-1:0] cap_val,
  input logic [NUM_CH-1:0]       cap_flag,
  input logic                    irq,
  input logic [NUM_CH-1:0][1:0]  mode,
  input logic [NUM_CH-1:0]       ie
);
  logic rst_d = 1'b0;
  logic unused_chk;
  assign unused_chk = ^wr_data;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      assert_reset_clear_R1: assert (cap_flag == '0 && irq == 1'b0 && cap_val == '0)
        else $error("outputs not cleared by reset");
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (cap_flag[g] && !(wr_en && wr_addr == ADDR_STAT && wr_data[FLAG_LSB + g]))
        |=> cap_flag[g]);

    assert_cap_flagged_R8: assert property (@(posedge clk) disable iff (rst)
      !$stable(cap_val[g*CNT_W +: CNT_W]) |-> cap_flag[g]);

    assert_off_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      (mode[g] == 2'b00 && !cap_flag[g]) |=> !cap_flag[g]);
  end

  assert_irq_set_R11: assert property (@(posedge clk) disable iff (rst)
    (|(cap_flag & ie)) |=> irq);

  assert_irq_clr_R11: assert property (@(posedge clk) disable iff (rst)
    !(|(cap_flag & ie)) |=> !irq);
endmodule

bind edge_capture_unit ecu_checker #(
  .CNT_W  (CNT_W),
  .NUM_CH (NUM_CH),
  .BUS_W  (BUS_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .cap_val  (cap_val),
  .cap_flag (cap_flag),
  .irq      (irq),
  .mode     (mode_q),
  .ie       (ie_q)
);

// File: tb/sim_edge_capture_unit.sv
`timescale 1ns/1ps
module sim_edge_capture_unit;
  localparam int CW = 32;
  localparam int NC = 2;
  localparam int BW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst;
  logic [CW-1:0]   cnt_val;
  logic            cnt_tick;
  logic [NC-1:0]   cap_pin;
  logic            wr_en;
  logic [1:0]      wr_addr;
  logic [BW-1:0]   wr_data;
  logic [NC*CW-1:0] cap_val;
  logic [NC-1:0]   cap_flag;
  logic            irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  edge_capture_unit #(.CNT_W(CW), .NUM_CH(NC), .BUS_W(BW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_tick(cnt_tick), .cap_pin(cap_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_val(cap_val), .cap_flag(cap_flag), .irq(irq)
  );

  // One clock: wait for the falling edge, then advance the bench counter.
  task automatic step();
    @(negedge clk);
    if (cnt_tick) cnt_val = cnt_val + 1;
  endtask

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] capv(input int ch);
    return cap_val[ch*CW +: CW];
  endfunction

  task automatic wr(input logic [1:0] a, input logic [BW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0;
  endtask

  task automatic set_modes(input logic [1:0] m0, input logic [1:0] m1);
    wr(2'd0, (BW'(m1) << 18) | (BW'(m0) << 16));
  endtask

  task automatic edge_to(input int ch, input logic v, output logic [CW-1:0] exp_val);
    cap_pin[ch] = v;
    exp_val = cnt_val + 2;
    repeat (4) step();
  endtask

  task automatic t_reset();
    chk("R1 cap0 after reset", capv(0), '0);
    chk("R1 cap1 after reset", capv(1), '0);
    chk("R1 flags after reset", CW'(cap_flag), '0);
    chk("R1 irq after reset", CW'(irq), '0);
  endtask

  task automatic t_rise();
    logic [CW-1:0] c, e;
    set_modes(2'b01, 2'b00);
    cap_pin[0] = 1'b1; c = cnt_val;
    step(); step();
    chk("R6 flag not set before sync latency", CW'(cap_flag[0]), 0);
    step();
    chk("R6 captured count two cycles after pin change", capv(0), c + 2);
    chk("R2 rising edge sets flag", CW'(cap_flag[0]), 1);
    step();
    wr(2'd1, 32'h8);
    chk("R9 write one clears flag", CW'(cap_flag[0]), 0);
    edge_to(0, 1'b0, e);
    chk("R2 falling edge ignored flag", CW'(cap_flag[0]), 0);
    chk("R2 falling edge ignored value", capv(0), c + 2);
  endtask

  task automatic t_fall();
    logic [CW-1:0] last, e;
    set_modes(2'b10, 2'b00);
    last = capv(0);
    edge_to(0, 1'b1, e);
    chk("R3 rising edge ignored flag", CW'(cap_flag[0]), 0);
    chk("R3 rising edge ignored value", capv(0), last);
    edge_to(0, 1'b0, e);
    chk("R3 falling edge captured", capv(0), e);
    chk("R3 falling edge flag", CW'(cap_flag[0]), 1);
    wr(2'd1, 32'h8);
  endtask

  task automatic t_both();
    logic [CW-1:0] e;
    set_modes(2'b11, 2'b00);
    edge_to(0, 1'b1, e);
    chk("R4 rise captured", capv(0), e);
    chk("R4 rise flag", CW'(cap_flag[0]), 1);
    wr(2'd1, 32'h8);
    edge_to(0, 1'b0, e);
    chk("R4 fall captured", capv(0), e);
    chk("R4 fall flag", CW'(cap_flag[0]), 1);
  endtask

  task automatic t_overwrite();
    logic [CW-1:0] e;
    edge_to(0, 1'b1, e);
    chk("R8 overwrite with flag set", capv(0), e);
    chk("R8 flag stays set", CW'(cap_flag[0]), 1);
  endtask

  task automatic t_clear();
    wr(2'd1, 32'h0);
    chk("R9 zero write keeps flag", CW'(cap_flag[0]), 1);
    wr(2'd1, 32'h10);
    chk("R9 other channel bit keeps flag", CW'(cap_flag[0]), 1);
    wr(2'd1, 32'h8);
    chk("R9 own bit clears flag", CW'(cap_flag[0]), 0);
  endtask

  task automatic t_collide();
    logic [CW-1:0] c, e;
    edge_to(0, 1'b0, e);
    cap_pin[0] = 1'b1; c = cnt_val;
    step(); step();
    wr(2'd1, 32'h8);
    chk("R10 clear and capture same edge keeps flag", CW'(cap_flag[0]), 1);
    chk("R10 value stored on collision", capv(0), c + 2);
    wr(2'd1, 32'h8);
    chk("R10 later clear works", CW'(cap_flag[0]), 0);
  endtask

  task automatic t_irq();
    logic [CW-1:0] e;
    edge_to(0, 1'b0, e);
    wr(2'd2, 32'h10);
    step();
    chk("R11 enable of other channel gives no irq", CW'(irq), 0);
    wr(2'd2, 32'h8);
    chk("R11 irq registered one cycle late", CW'(irq), 0);
    step();
    chk("R11 irq asserted", CW'(irq), 1);
    wr(2'd1, 32'h8);
    chk("R11 irq holds one cycle after clear", CW'(irq), 1);
    step();
    chk("R11 irq drops", CW'(irq), 0);
    wr(2'd2, 32'h0);
  endtask

  task automatic t_off();
    logic [CW-1:0] last0, last1, e;
    set_modes(2'b00, 2'b00);
    last0 = capv(0); last1 = capv(1);
    edge_to(0, 1'b1, e);
    edge_to(0, 1'b0, e);
    edge_to(1, 1'b1, e);
    edge_to(1, 1'b0, e);
    chk("R5 disabled keeps value ch0", capv(0), last0);
    chk("R5 disabled keeps value ch1", capv(1), last1);
    chk("R5 disabled no flags", CW'(cap_flag), 0);
  endtask

  task automatic t_fields();
    logic [CW-1:0] e;
    set_modes(2'b00, 2'b01);
    edge_to(0, 1'b1, e);
    chk("R7 bits 17:16 zero leave ch0 off", CW'(cap_flag[0]), 0);
    edge_to(1, 1'b1, e);
    chk("R7 bits 19:18 arm ch1 value", capv(1), e);
    chk("R7 bits 19:18 arm ch1 flag", CW'(cap_flag[1]), 1);
    wr(2'd1, 32'h10);
    wr(2'd2, 32'h000F_0000);
    wr(2'd3, 32'h000F_0000);
    edge_to(1, 1'b0, e);
    chk("R7 other addresses leave ch1 rise-only", CW'(cap_flag[1]), 0);
    edge_to(0, 1'b0, e);
    chk("R7 other addresses leave ch0 off", CW'(cap_flag[0]), 0);
  endtask

  task automatic t_tick();
    logic [CW-1:0] c, last;
    last = capv(1);
    cnt_tick = 1'b0;
    c = cnt_val;
    cap_pin[1] = 1'b1;
    repeat (4) step();
    chk("R12 no capture while count paused flag", CW'(cap_flag[1]), 0);
    chk("R12 no capture while count paused value", capv(1), last);
    cnt_tick = 1'b1;
    step();
    chk("R12 held edge stored at first tick", capv(1), c);
    chk("R12 held edge flag", CW'(cap_flag[1]), 1);
    wr(2'd1, 32'h10);
  endtask

  task automatic t_indep();
    logic [CW-1:0] e, e0, last1;
    set_modes(2'b11, 2'b11);
    last1 = capv(1);
    edge_to(0, 1'b1, e0);
    chk("R13 ch0 captured", capv(0), e0);
    chk("R13 ch1 flag untouched", CW'(cap_flag[1]), 0);
    chk("R13 ch1 value untouched", capv(1), last1);
    edge_to(1, 1'b0, e);
    chk("R13 ch1 captured", capv(1), e);
    chk("R13 ch0 value untouched", capv(0), e0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R1-all actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cnt_val = 32'h1000_0000; cnt_tick = 1'b1; cap_pin = '0;
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0;
    repeat (4) step();
    rst = 1'b0;
    step();
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_overwrite();
    t_clear();
    t_collide();
    t_irq();
    t_off();
    t_fields();
    t_tick();
    t_indep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule